// File: doc/BRIEF.md
# Reset Hold Length Meter

This block measures how long an external, active-low reset push-button is kept pressed. The raw button level is asynchronous to the block clock. It passes through a chain of synchronising flops. While the synchronised level is low, a counter advances once per clock. With the intended 25 MHz reference, each count is 40 ns.

The counter saturates at its all-ones value, so a very long press cannot wrap back to a small count. The count holds when the button is released. Software reads the count through one 32-bit register. Writing a 1 to bit 31 of that register clears the count for the next measurement.

The comparison against a threshold in seconds belongs to software: one second is 25,000,000 counts. With the default 29-bit width the largest measurable press is about 21.4 seconds. Generating the system reset itself is not part of this block.

Top module: `hold_length_meter`

## Requirements
- R1: After the asynchronous reset the length register reads zero.
- R2: Each rising clock edge at which the synchronised button level is low adds one to the count. A press that covers N rising edges yields a count of N once it has settled.
- R3: While the synchronised level is high and no clear is written, the count does not change.
- R4: Presses that are not separated by a clear accumulate into the same count.
- R5: A write with bit 31 of the write data set to 1 makes the count zero at the next rising edge. This clear takes priority over counting and over saturation.
- R6: A write with bit 31 of the write data at 0 has no effect on the count, whatever the other bits hold.
- R7: Read data bits CNT_W-1:0 carry the count. Every bit above them, bit 31 included, reads as zero.
- R8: The count saturates at 2^CNT_W-1. It stays there for as long as the press continues, and through further presses.
- R9: A clear written while the button is held restarts the count from zero, and counting continues. After the clear edge, each further low edge adds one, plus the two edges still in the synchroniser.
- R10: The button level reaches the counter through two synchronising flops. When the button goes low before rising edge 1, the count still reads zero after edge 2 and reads one after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock (25 MHz in the intended use) |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| hold_ni | input | 1 | Asynchronous active-low button level being measured |
| reg_wr_i | input | 1 | Write strobe for the length register, one write per cycle it is high |
| reg_wdata_i | input | 32 | Write data; bit 31 = 1 requests a clear, other bits are ignored |
| reg_rdata_o | output | 32 | Length register: count on bits CNT_W-1:0, zeros above |

## Verification
The assertions take for granted that reg_wr_i and bit 31 of reg_wdata_i carry known values at every rising edge after reset. They also assume the button input reaches the counter only through the synchroniser, so every property is stated against the synchronised level. The stimulus meets these assumptions by changing the button, the write strobe and the write data only on falling edges. Each write strobe covers exactly one rising edge. The count is sampled only after the two synchroniser stages and the counter register have settled. Saturation is exercised with a reduced counter width, so that the all-ones value is reached within a few hundred cycles.

// File: rtl/hlm_pkg.sv
package hlm_pkg;
  localparam int REG_W   = 32;
  localparam int CLR_BIT = REG_W - 1;
endpackage

// File: rtl/hlm_sync.sv
module hlm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  // Reset to the released (high) level so no count starts out of reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/hlm_sat_cnt.sv
module hlm_sat_cnt #(
  parameter int W = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hlm_regif.sv
module hlm_regif import hlm_pkg::*; #(
  parameter int W = 29
) (
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [W-1:0]     cnt_i,
  output logic             clr_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int PAD_W = REG_W - W;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[CLR_BIT-1:0];

  assign clr_o   = wr_i & wdata_i[CLR_BIT];
  assign rdata_o = {{PAD_W{1'b0}}, cnt_i};
endmodule

// File: rtl/hold_length_meter.sv
module hold_length_meter import hlm_pkg::*; #(
  parameter int CNT_W       = 29,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic             hold_sync_n;
  logic             held_w;
  logic             clr_w;
  logic [CNT_W-1:0] cnt_w;

  hlm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_ni),
    .q_o    (hold_sync_n)
  );

  assign held_w = ~hold_sync_n;

  hlm_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (held_w),
    .clr_i  (clr_w),
    .cnt_o  (cnt_w)
  );

  hlm_regif #(.W(CNT_W)) u_regif (
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt_w),
    .clr_o   (clr_w),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/hlm_checker.sv
module hlm_checker import hlm_pkg::*; #(
  parameter int CNT_W = 29
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             held_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic clr_req;
  assign clr_req = reg_wr_i & reg_wdata_i[CLR_BIT];

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && !clr_req && cnt_i != CNT_MAX) |=> (cnt_i == $past(cnt_i) + 1'b1));

  a_r3_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_i && !clr_req) |=> $stable(cnt_i));

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> (reg_rdata_o == '0));

  a_r6_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_wdata_i[CLR_BIT] && !held_i) |=> $stable(reg_rdata_o));

  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:CNT_W] == '0);

  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX && !clr_req) |=> (cnt_i == CNT_MAX));
endmodule

bind hold_length_meter hlm_checker #(.CNT_W(CNT_W)) u_hlm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .held_i      (held_w),
  .cnt_i       (cnt_w)
);

// File: tb/tb_hold_length_meter.sv
module tb_hold_length_meter;
  localparam int CW = 8;
  localparam logic [31:0] SAT_VAL = 32'd255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_n = 1'b1;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  hold_length_meter #(.CNT_W(CW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .hold_ni     (hold_n),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Button low across n rising edges.
  task automatic press(input int n);
    @(negedge clk) hold_n = 1'b0;
    repeat (n) @(negedge clk);
    hold_n = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [31:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) begin wr = 1'b0; wdata = '0; end
  endtask

  task automatic expect_val(input logic [31:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares against the port.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata, 32'd0, "R1 reset value");
    rst_n = 1'b1;
    settle();
    expect_val(32'd0, "R1 after reset release");

    press(5); settle();
    expect_val(32'd5, "R2 press of 5 edges");

    press(3); settle();
    expect_val(32'd8, "R4 second press accumulates");

    repeat (20) @(negedge clk);
    expect_val(32'd8, "R3 stable while released");

    wr_reg(32'h7FFF_FFFF); settle();
    expect_val(32'd8, "R6 write without bit 31 ignored");

    wr_reg(32'h8000_0000);
    expect_val(32'd0, "R5 clear write");

    // R10 synchroniser latency
    @(negedge clk) hold_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(rdata, 32'd0, "R10 zero after edge 2");
    @(negedge clk);
    chk(rdata, 32'd1, "R10 one after edge 3");
    repeat (2) @(negedge clk);
    hold_n = 1'b1;
    settle();
    expect_val(32'd5, "R10 R2 total of 5 edges");

    wr_reg(32'h8000_0000);
    press(1); settle();
    expect_val(32'd1, "R2 single edge press");

    wr_reg(32'h8000_0000);
    press(12); settle();
    expect_val(32'd12, "R5 new press after clear starts at zero");

    wr_reg(32'hFFFF_FFFF);
    expect_val(32'd0, "R5 R7 all-ones write clears and upper bits zero");

    press(300); settle();
    expect_val(SAT_VAL, "R8 R7 saturation value");

    press(10); settle();
    expect_val(SAT_VAL, "R8 stays at max");

    wr_reg(32'h8000_0000);
    expect_val(32'd0, "R5 clear from max");

    // R9 clear during an active press: 3 low edges after clear edge -> 3+2
    @(negedge clk) hold_n = 1'b0;
    repeat (6) @(negedge clk);
    wr = 1'b1; wdata = 32'h8000_0000;
    @(negedge clk) begin wr = 1'b0; wdata = '0; end
    repeat (3) @(negedge clk);
    hold_n = 1'b1;
    settle();
    expect_val(32'd5, "R9 clear during press");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule